// File: doc/BRIEF.md
# DisplayPort Main-Link Training Sequencer

This block runs the source side of main-link training for a link of one, two or four lanes. It first sends the link configuration to the sink. It then runs a clock-recovery phase on training pattern 1, followed by an equalization phase on training pattern 2. Between attempts it raises the transmit swing and pre-emphasis to the levels the sink asks for. When training ends, it turns the pattern off at both ends and reports whether the link is usable.

Sink traffic goes through a simple port that carries one request at a time. A request is a write or a read, with a 16-bit sink address, a byte count and up to nine payload bytes. A response brings back an ok flag and up to six status bytes. The block owns no physical channel and no analog drive. Lane count comes in on `lane_mode` (00 = lane 0 only, 01 = lanes 0-1, 10 or 11 = lanes 0-3). Every lane receives the same drive byte on `lane_drive`.

Top module: `link_train_ctrl`

## Requirements
- R1: A `start` pulse causes a 9-byte write of `link_cfg` to sink address 0x100, with byte k taken from bits [8k+7:8k]. This write is the first request of the run, and its ok flag has no effect on the sequence.
- R2: Each attempt issues three requests in this order: a 1-byte write to 0x102, then a 4-byte write to 0x103, then a 6-byte read from 0x202. The 0x102 byte is the pattern code (1 for clock recovery, 2 for equalization). `train_pat` already shows that code when the request appears. A request holds its address until its response arrives.
- R3: The status read is issued CR_WAIT_CYC cycles after the 0x103 response is accepted in clock recovery, and EQ_WAIT_CYC cycles after it in equalization.
- R4: In the status bytes, byte 0 holds lanes 0 and 1 and byte 1 holds lanes 2 and 3. The even lane uses the low nibble and the odd lane the high nibble. Within a nibble, bit 0 is CR-done. Clock recovery passes, and `cr_locked` is set, only when every active lane has CR-done. Inactive lanes are ignored.
- R5: Equalization passes only when two conditions hold together: byte 2 bit 0 (inter-lane alignment) is set, and every active lane has nibble bits 0, 1 and 2 (CR-done, EQ-done, symbol-locked) all set.
- R6: Adjust requests sit in bytes 4 and 5, laid out per lane like bytes 0 and 1, with swing in nibble bits 1:0 and pre-emphasis in bits 3:2. The new drive takes the highest swing and the highest pre-emphasis over the active lanes. The 0x103 write carries four identical copies of the drive byte, and `lane_drive` shows the same byte. The drive byte layout is: bits 1:0 swing, bit 2 max-swing flag, bits 4:3 pre-emphasis, bit 5 max-pre-emphasis flag.
- R7: Swing is clamped to level 2, and reaching level 2 sets the max-swing flag. Pre-emphasis is clamped to a ceiling that depends on swing: 2 for swing 0 or 1, 1 for swing 2, 0 for swing 3. Reaching the ceiling sets the max-pre-emphasis flag.
- R8: Clock recovery gives up when a failed attempt ran with the max-swing flag set. It also gives up on the sixth consecutive failed attempt at one swing level. Equalization follows either way.
- R9: Equalization gives up after its seventh failed attempt.
- R10: A response with ok low during an attempt ends that phase at once. In clock recovery, equalization then follows. In equalization, training ends as failed.
- R11: Training ends with `train_pat` at 0, followed by a 1-byte write of 0x00 to 0x102. After that write's response, `done` rises and `pass` gives the equalization result. No request is made while `done` is high.
- R12: After reset, all outputs are 0. Every `start` restarts from clock recovery with the drive byte at 0 and clears `done`, `pass` and `cr_locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins or restarts training |
| lane_mode | input | 2 | Active lanes: 00 one, 01 two, 1x four |
| link_cfg | input | 72 | Nine configuration bytes for the sink |
| req_valid | output | 1 | Request pending, held until response |
| req_wr | output | 1 | 1 write, 0 read |
| req_addr | output | 16 | Sink address |
| req_len | output | 4 | Byte count |
| req_wdata | output | 72 | Write payload, byte k at [8k+7:8k] |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_ok | input | 1 | Response succeeded |
| rsp_rdata | input | 48 | Six status bytes, byte k at [8k+7:8k] |
| lane_drive | output | 32 | Drive byte per lane, lane k at [8k+7:8k] |
| train_pat | output | 2 | Source pattern: 0 off, 1 pattern 1, 2 pattern 2 |
| cr_locked | output | 1 | Clock recovery passed in this run |
| done | output | 1 | Training finished |
| pass | output | 1 | Equalization passed |

## Verification
A request appears in the cycle after the edge that accepts the previous response. The status read comes exactly the programmed wait after the 0x103 response. The bench's sink model counts falling edges, and for every read it checks that gap against the wait plus the one edge at which the design samples the response. Drive, pattern and flag outputs are checked on the falling edge after `done` is first seen, and pattern order is checked when each request is captured, so no check lands on the edge that changes the value. An attempt-by-attempt model in the bench gives the expected attempt counts and final drive for a sweep over lane modes, all requested swing and pre-emphasis levels, and sink pass points.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int NLANE       = 4;
    localparam int SW_MAX_BIT  = 2;
    localparam int PE_LSB      = 3;
    localparam int PE_MAX_BIT  = 5;

    localparam logic [1:0] PAT_OFF = 2'd0;
    localparam logic [1:0] PAT_CR  = 2'd1;
    localparam logic [1:0] PAT_EQ  = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CFG,
        S_CR_PAT,
        S_CR_LANE,
        S_CR_WAIT,
        S_CR_READ,
        S_EQ_PAT,
        S_EQ_LANE,
        S_EQ_WAIT,
        S_EQ_READ,
        S_FIN,
        S_DONE
    } lt_state_e;

    typedef struct packed {
        lt_state_e   st;
        logic [7:0]  drive;
        logic [1:0]  pat;
        logic [1:0]  last_sw;
        logic        last_vld;
        logic [2:0]  tries;
        logic        cr_lock;
        logic        done;
        logic        pass;
    } lt_regs_t;

    function automatic logic [NLANE-1:0] lane_mask(input logic [1:0] mode);
        logic [NLANE-1:0] m;
        unique case (mode)
            2'b00:   m = NLANE'(1);
            2'b01:   m = NLANE'(3);
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [1:0] pe_ceiling(input logic [1:0] sw);
        logic [1:0] c;
        unique case (sw)
            2'd0, 2'd1: c = 2'd2;
            2'd2:       c = 2'd1;
            default:    c = 2'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lt_status_decode.sv
module lt_status_decode #(
    parameter int NLANE  = 4,
    parameter int SBYTES = 2 * ((NLANE + 1) / 2) + 2
) (
    input  logic [8*SBYTES-1:0] stat,
    input  logic [NLANE-1:0]    act,
    output logic                cr_ok,
    output logic                eq_ok,
    output logic [1:0]          req_sw,
    output logic [1:0]          req_pe
);
    localparam int LBYTES  = (NLANE + 1) / 2;
    localparam int ALIGN_B = LBYTES;
    localparam int ADJ_B   = LBYTES + 2;

    logic [NLANE-1:0] lane_cr;
    logic [NLANE-1:0] lane_eq;
    logic [1:0]       lane_sw [NLANE];
    logic [1:0]       lane_pe [NLANE];

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [3:0] nib;
        logic [3:0] adj;
        assign nib = stat[8*(l/2) + 4*(l%2) +: 4];
        assign adj = stat[8*(ADJ_B + l/2) + 4*(l%2) +: 4];
        assign lane_cr[l] = nib[0];
        assign lane_eq[l] = &nib[2:0];
        assign lane_sw[l] = act[l] ? adj[1:0] : 2'd0;
        assign lane_pe[l] = act[l] ? adj[3:2] : 2'd0;
    end

    assign cr_ok = &(lane_cr | ~act);
    assign eq_ok = stat[8*ALIGN_B] & (&(lane_eq | ~act));

    always_comb begin
        req_sw = 2'd0;
        req_pe = 2'd0;
        for (int l = 0; l < NLANE; l++) begin
            if (lane_sw[l] > req_sw) req_sw = lane_sw[l];
            if (lane_pe[l] > req_pe) req_pe = lane_pe[l];
        end
    end

endmodule

// File: rtl/lt_drive_adjust.sv
module lt_drive_adjust
    import lt_pkg::*;
(
    input  logic [1:0] req_sw,
    input  logic [1:0] req_pe,
    output logic [7:0] drive
);
    localparam logic [1:0] SW_LIMIT = 2'd2;

    always_comb begin
        logic [1:0] v;
        logic [1:0] p;
        logic [1:0] ceil;
        logic       vf;
        logic       pf;
        v  = req_sw;
        vf = 1'b0;
        if (v >= SW_LIMIT) begin
            v  = SW_LIMIT;
            vf = 1'b1;
        end
        ceil = pe_ceiling(v);
        p    = req_pe;
        pf   = 1'b0;
        if (p >= ceil) begin
            p  = ceil;
            pf = 1'b1;
        end
        drive = 8'd0;
        drive[1:0]              = v;
        drive[SW_MAX_BIT]       = vf;
        drive[PE_LSB +: 2]      = p;
        drive[PE_MAX_BIT]       = pf;
    end

endmodule

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } tmr_t;

    tmr_t q, d;

    assign expired = q.run && (q.cnt == '0);

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = load_val;
            d.run = 1'b1;
        end else if (q.run) begin
            if (q.cnt == '0) d.run = 1'b0;
            else             d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    AST_TMR_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (q.run && q.cnt != '0 && !load) |=> (q.run && q.cnt == $past(q.cnt) - 1'b1)); // R3

endmodule

// File: rtl/link_train_ctrl.sv
module link_train_ctrl
    import lt_pkg::*;
#(
    parameter int          CFG_BYTES   = 9,
    parameter int          ADDR_W      = 16,
    parameter int          CR_WAIT_CYC = 20000,
    parameter int          EQ_WAIT_CYC = 80000,
    parameter logic [15:0] CFG_ADDR    = 16'h0100,
    parameter logic [15:0] PAT_ADDR    = 16'h0102,
    parameter logic [15:0] LANE_ADDR   = 16'h0103,
    parameter logic [15:0] STAT_ADDR   = 16'h0202,
    parameter int          SAME_LIMIT  = 5,
    parameter int          EQ_LIMIT    = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [1:0]             lane_mode,
    input  logic [8*CFG_BYTES-1:0] link_cfg,
    output logic                   req_valid,
    output logic                   req_wr,
    output logic [ADDR_W-1:0]      req_addr,
    output logic [3:0]             req_len,
    output logic [8*CFG_BYTES-1:0] req_wdata,
    input  logic                   rsp_valid,
    input  logic                   rsp_ok,
    input  logic [47:0]            rsp_rdata,
    output logic [8*NLANE-1:0]     lane_drive,
    output logic [1:0]             train_pat,
    output logic                   cr_locked,
    output logic                   done,
    output logic                   pass
);
    localparam int SBYTES  = 2 * ((NLANE + 1) / 2) + 2;
    localparam int MAXWAIT = (CR_WAIT_CYC > EQ_WAIT_CYC) ? CR_WAIT_CYC : EQ_WAIT_CYC;
    localparam int CW      = $clog2(MAXWAIT + 1);

    lt_regs_t q, d;

    logic             cr_ok, eq_ok;
    logic [1:0]       req_sw, req_pe;
    logic [7:0]       adj_drive;
    logic             tmr_load, tmr_exp;
    logic [CW-1:0]    tmr_val;
    logic [NLANE-1:0] act;

    assign act = lane_mask(lane_mode);

    lt_status_decode #(.NLANE(NLANE), .SBYTES(SBYTES)) u_dec (
        .stat   (rsp_rdata[8*SBYTES-1:0]),
        .act    (act),
        .cr_ok  (cr_ok),
        .eq_ok  (eq_ok),
        .req_sw (req_sw),
        .req_pe (req_pe)
    );

    lt_drive_adjust u_adj (
        .req_sw (req_sw),
        .req_pe (req_pe),
        .drive  (adj_drive)
    );

    lt_wait_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (start) begin
            d    = '0;
            d.st = S_CFG;
        end else begin
            unique case (q.st)
                S_CFG: if (rsp_valid) begin
                    d.st       = S_CR_PAT;
                    d.pat      = PAT_CR;
                    d.tries    = '0;
                    d.last_vld = 1'b0;
                end
                S_CR_PAT, S_CR_LANE: if (rsp_valid) begin
                    if (!rsp_ok) begin
                        d.st    = S_EQ_PAT;
                        d.pat   = PAT_EQ;
                        d.tries = '0;
                    end else if (q.st == S_CR_PAT) begin
                        d.st = S_CR_LANE;
                    end else begin
                        d.st     = S_CR_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(CR_WAIT_CYC - 1);
                    end
                end
                S_CR_WAIT: if (tmr_exp) d.st = S_CR_READ;
                S_CR_READ: if (rsp_valid) begin
                    if (!rsp_ok || cr_ok || q.drive[SW_MAX_BIT]) begin
                        d.cr_lock = rsp_ok && cr_ok;
                        d.st      = S_EQ_PAT;
                        d.pat     = PAT_EQ;
                        d.tries   = '0;
                    end else if (q.last_vld && q.last_sw == q.drive[1:0]
                                 && q.tries == 3'(SAME_LIMIT - 1)) begin
                        d.st    = S_EQ_PAT;
                        d.pat   = PAT_EQ;
                        d.tries = '0;
                    end else begin
                        if (q.last_vld && q.last_sw == q.drive[1:0])
                            d.tries = q.tries + 1'b1;
                        else
                            d.tries = '0;
                        d.last_sw  = q.drive[1:0];
                        d.last_vld = 1'b1;
                        d.drive    = adj_drive;
                        d.st       = S_CR_PAT;
                    end
                end
                S_EQ_PAT, S_EQ_LANE: if (rsp_valid) begin
                    if (!rsp_ok) begin
                        d.st  = S_FIN;
                        d.pat = PAT_OFF;
                    end else if (q.st == S_EQ_PAT) begin
                        d.st = S_EQ_LANE;
                    end else begin
                        d.st     = S_EQ_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(EQ_WAIT_CYC - 1);
                    end
                end
                S_EQ_WAIT: if (tmr_exp) d.st = S_EQ_READ;
                S_EQ_READ: if (rsp_valid) begin
                    if (!rsp_ok || eq_ok || q.tries > 3'(EQ_LIMIT)) begin
                        d.pass = rsp_ok && eq_ok;
                        d.st   = S_FIN;
                        d.pat  = PAT_OFF;
                    end else begin
                        d.drive = adj_drive;
                        d.tries = q.tries + 1'b1;
                        d.st    = S_EQ_PAT;
                    end
                end
                S_FIN: if (rsp_valid) begin
                    d.st   = S_DONE;
                    d.done = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    always_comb begin
        req_valid = 1'b0;
        req_wr    = 1'b1;
        req_addr  = PAT_ADDR;
        req_len   = 4'd1;
        req_wdata = '0;
        unique case (q.st)
            S_CFG: begin
                req_valid = 1'b1;
                req_addr  = CFG_ADDR;
                req_len   = 4'(CFG_BYTES);
                req_wdata = link_cfg;
            end
            S_CR_PAT, S_EQ_PAT, S_FIN: begin
                req_valid      = 1'b1;
                req_wdata[1:0] = q.pat;
            end
            S_CR_LANE, S_EQ_LANE: begin
                req_valid               = 1'b1;
                req_addr                = LANE_ADDR;
                req_len                 = 4'(NLANE);
                req_wdata[8*NLANE-1:0]  = {NLANE{q.drive}};
            end
            S_CR_READ, S_EQ_READ: begin
                req_valid = 1'b1;
                req_wr    = 1'b0;
                req_addr  = STAT_ADDR;
                req_len   = 4'(SBYTES);
            end
            default: ;
        endcase
    end

    assign lane_drive = {NLANE{q.drive}};
    assign train_pat  = q.pat;
    assign cr_locked  = q.cr_lock;
    assign done       = q.done;
    assign pass       = q.pass;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid && !start) |=> req_valid); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid && !start) |=> $stable(req_addr)); // R2
    AST_SWING_CLAMP: assert property (@(posedge clk) disable iff (rst)
        lane_drive[1:0] <= 2'd2); // R7
    AST_PE_CEILING: assert property (@(posedge clk) disable iff (rst)
        lane_drive[PE_LSB +: 2] <= pe_ceiling(lane_drive[1:0])); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (train_pat == PAT_OFF && !req_valid)); // R11
    AST_CR_TRIES: assert property (@(posedge clk) disable iff (rst)
        (train_pat == PAT_CR) |-> (q.tries < 3'(SAME_LIMIT))); // R8
    AST_EQ_TRIES: assert property (@(posedge clk) disable iff (rst)
        (train_pat == PAT_EQ) |-> (q.tries <= 3'(EQ_LIMIT + 1))); // R9

endmodule

// File: tb/link_train_ctrl_test.sv
`timescale 1ns/1ps
module link_train_ctrl_test;
    localparam int CRW = 6;
    localparam int EQW = 14;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  lane_mode = 2'b10;
    logic [71:0] link_cfg = 72'h0;
    logic        req_valid, req_wr;
    logic [15:0] req_addr;
    logic [3:0]  req_len;
    logic [71:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_ok = 1'b0;
    logic [47:0] rsp_rdata = 48'h0;
    logic [31:0] lane_drive;
    logic [1:0]  train_pat;
    logic        cr_locked, done, pass;

    always #2.5 clk = ~clk;

    link_train_ctrl #(.CR_WAIT_CYC(CRW), .EQ_WAIT_CYC(EQW)) uut (
        .clk(clk), .rst(rst), .start(start), .lane_mode(lane_mode),
        .link_cfg(link_cfg), .req_valid(req_valid), .req_wr(req_wr),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
        .lane_drive(lane_drive), .train_pat(train_pat),
        .cr_locked(cr_locked), .done(done), .pass(pass)
    );

    int n_chk = 0;
    int n_bad = 0;

    // scenario
    int sc_lanes, sc_cr_n, sc_eq_n, sc_mode, sc_sw, sc_pe, fail_at;
    // sink model bookkeeping
    int tick = 0, rsp_n, req_seen, cr_reads, eq_reads, cr_pats, eq_pats;
    int cfg_bad, order_bad, lane_bad, gap_bad, last_lane_tick, sink_pat;
    int first_lane, last_wr_addr, last_wr_byte;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] status_for(input int phase, input int idx);
        logic [47:0] s;
        int top;
        bit ps;
        s   = '0;
        top = sc_lanes - 1;
        ps  = (phase == 1) ? (sc_cr_n != 0 && idx >= sc_cr_n) : (sc_eq_n != 0 && idx >= sc_eq_n);
        for (int l = 0; l < 4; l++) begin
            logic [3:0] nib, adj;
            nib = 4'h0;
            if (l < sc_lanes) begin
                nib = 4'h7;
                if (!ps && l == top) begin
                    if (phase == 1)        nib = 4'h6;
                    else if (sc_mode == 1) nib = 4'h3;
                    else if (sc_mode == 2) nib = 4'h5;
                end
                adj[1:0] = (l == top) ? 2'(sc_sw) : 2'd0;
                adj[3:2] = (l == 0)   ? 2'(sc_pe) : 2'd0;
            end else begin
                adj = 4'hF;
            end
            s[8*(l/2) + 4*(l%2) +: 4]     = nib;
            s[8*(4 + l/2) + 4*(l%2) +: 4] = adj;
        end
        s[16] = (phase == 1) ? 1'b1 : (ps || sc_mode != 0);
        return s;
    endfunction

    function automatic logic [7:0] exp_adj(input int sw, input int pe);
        int v, p, vf, pf, c;
        v = sw; vf = 0;
        if (v >= 2) begin v = 2; vf = 1; end
        c = (v <= 1) ? 2 : (v == 2) ? 1 : 0;
        p = pe; pf = 0;
        if (p >= c) begin p = c; pf = 1; end
        return 8'(v | (vf << 2) | (p << 3) | (pf << 5));
    endfunction

    // sink model / responder
    initial begin
        bit busy;
        int lat;
        bit cur_wr;
        logic [15:0] cur_addr;
        logic [71:0] cur_wd;
        logic [47:0] cur_rd;
        busy = 0; lat = 0; cur_wr = 0; cur_addr = '0; cur_wd = '0; cur_rd = '0;
        forever begin
            @(negedge clk);
            tick++;
            if (rsp_valid) begin
                rsp_valid = 1'b0;
            end else if (busy) begin
                if (lat == 0) begin
                    rsp_n++;
                    rsp_ok    = (rsp_n != fail_at);
                    rsp_rdata = cur_rd;
                    rsp_valid = 1'b1;
                    busy      = 0;
                    if (cur_wr && cur_addr == 16'h0103) last_lane_tick = tick;
                end else lat--;
            end else if (req_valid) begin
                busy = 1; lat = LAT;
                cur_wr = req_wr; cur_addr = req_addr; cur_wd = req_wdata; cur_rd = '0;
                req_seen++;
                if (req_seen == 1 && !(req_wr && req_addr == 16'h0100 && req_len == 4'd9 && req_wdata == link_cfg))
                    cfg_bad++;
                if (req_wr) begin
                    last_wr_addr = int'(req_addr);
                    last_wr_byte = int'(req_wdata[7:0]);
                end
                if (req_wr && req_addr == 16'h0102) begin
                    if (req_len != 4'd1 || int'(train_pat) != int'(req_wdata[7:0])) order_bad++;
                    sink_pat = int'(req_wdata[7:0]);
                    if (sink_pat == 1) cr_pats++;
                    if (sink_pat == 2) eq_pats++;
                end else if (req_wr && req_addr == 16'h0103) begin
                    if (req_len != 4'd4 || req_wdata[31:0] != {4{req_wdata[7:0]}} ||
                        req_wdata[31:0] != lane_drive) lane_bad++;
                    if (first_lane < 0) first_lane = int'(req_wdata[7:0]);
                end else if (!req_wr) begin
                    if (req_addr != 16'h0202 || req_len != 4'd6) order_bad++;
                    if (tick - last_lane_tick != ((sink_pat == 1) ? CRW + 1 : EQW + 1)) gap_bad++;
                    if (sink_pat == 1) begin cr_reads++; cur_rd = status_for(1, cr_reads); end
                    else               begin eq_reads++; cur_rd = status_for(2, eq_reads); end
                end
            end
        end
    end

    task automatic run_case(input int lanes, input int crn, input int eqn, input int mode,
                            input int sw, input int pe, input int fa,
                            input int e_cr, input int e_eq, input bit e_pass,
                            input bit e_lock, input logic [7:0] e_drv);
        int w;
        sc_lanes = lanes; sc_cr_n = crn; sc_eq_n = eqn; sc_mode = mode;
        sc_sw = sw; sc_pe = pe; fail_at = fa;
        lane_mode = (lanes == 1) ? 2'b00 : (lanes == 2) ? 2'b01 : 2'(2 + (mode & 1));
        link_cfg = {8'h00, 8'(lanes), 8'(sw), 8'(pe), 8'h5A, 8'(crn), 8'(eqn), 8'h81, 8'h0A};
        @(negedge clk);
        rsp_n = 0; req_seen = 0; cr_reads = 0; eq_reads = 0; cr_pats = 0; eq_pats = 0;
        cfg_bad = 0; order_bad = 0; lane_bad = 0; gap_bad = 0; sink_pat = 0;
        first_lane = -1; last_wr_addr = 0; last_wr_byte = -1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done, "R12 done cleared by start", done, 0);
        w = 0;
        while (!done && w < 4000) begin @(negedge clk); w++; end
        check(done, "R11 done raised", done, 1);                                   // R11
        check(train_pat == 2'd0, "R11 pattern off", train_pat, 0);                 // R11
        check(last_wr_addr == 'h102 && last_wr_byte == 0, "R11 sink pattern disable",
              last_wr_addr, 'h102);
        check(pass == e_pass, "R5/R9 pass flag", pass, e_pass);                    // R5 R9
        check(cr_locked == e_lock, "R4 cr_locked", cr_locked, e_lock);              // R4
        check(lane_drive == {4{e_drv}}, "R6/R7 final drive", lane_drive, {4{e_drv}}); // R6 R7
        check(cr_pats == e_cr, "R8 clock-recovery attempts", cr_pats, e_cr);        // R8
        check(eq_pats == e_eq, "R9 equalization attempts", eq_pats, e_eq);          // R9
        check(cfg_bad == 0, "R1 configuration write first", cfg_bad, 0);            // R1
        check(order_bad == 0, "R2 request order and pattern", order_bad, 0);        // R2
        check(lane_bad == 0, "R6 lane bytes", lane_bad, 0);                         // R6
        check(gap_bad == 0, "R3 status read wait", gap_bad, 0);                     // R3
        check(first_lane == 0, "R12 drive restarts at zero", first_lane, 0);        // R12
    endtask

    // attempt-by-attempt expectation from the requirements
    task automatic predict(input int crn, input int eqn, input int sw, input int pe,
                           output int e_cr, output int e_eq, output bit e_pass,
                           output bit e_lock, output logic [7:0] e_drv);
        logic [7:0] drv, a;
        int last, tries;
        a = exp_adj(sw, pe);
        drv = 8'h00; last = -1; tries = 0; e_cr = 0; e_eq = 0; e_pass = 0; e_lock = 0;
        forever begin
            e_cr++;
            if (crn != 0 && e_cr >= crn) begin e_lock = 1; break; end
            if (drv[2]) break;
            if (int'(drv[1:0]) == last) begin
                tries++;
                if (tries == 5) break;
            end else tries = 0;
            last = int'(drv[1:0]);
            drv = a;
        end
        tries = 0;
        forever begin
            e_eq++;
            if (eqn != 0 && e_eq >= eqn) begin e_pass = 1; break; end
            if (tries > 5) break;
            drv = a;
            tries++;
        end
        e_drv = drv;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e_cr, e_eq, k;
        bit e_pass, e_lock;
        logic [7:0] e_drv;
        repeat (4) @(negedge clk);
        // R12: reset state
        check(!done && !pass && !cr_locked && train_pat == 0 && lane_drive == 0 && !req_valid,
              "R12 reset outputs", {done, pass, cr_locked, train_pat, req_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!req_valid, "R12 idle without start", req_valid, 0);
        k = 0;
        for (int li = 0; li < 3; li++) begin
            for (int sw = 0; sw < 4; sw++) begin
                for (int pe = 0; pe < 4; pe++) begin
                    for (int c = 0; c < 3; c++) begin
                        int crn, eqn, lanes;
                        lanes = (li == 0) ? 1 : (li == 1) ? 2 : 4;
                        crn = (c == 0) ? 2 : (c == 1) ? 0 : 3;
                        eqn = (c == 0) ? 1 : (c == 1) ? 0 : 4;
                        predict(crn, eqn, sw, pe, e_cr, e_eq, e_pass, e_lock, e_drv);
                        run_case(lanes, crn, eqn, k % 3, sw, pe, 0,
                                 e_cr, e_eq, e_pass, e_lock, e_drv);
                        k++;
                    end
                end
            end
        end
        // R10: failed status read in clock recovery, equalization still runs
        run_case(4, 1, 1, 0, 1, 1, 4, 1, 1, 1'b1, 1'b0, 8'h00);
        // R10: failed lane write in equalization ends training as failed
        run_case(4, 1, 1, 0, 1, 1, 6, 1, 1, 1'b0, 1'b1, 8'h00);
        // R1: a failed configuration write does not stop training
        run_case(2, 1, 1, 0, 2, 0, 1, 1, 1, 1'b1, 1'b1, 8'h00);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule